// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the command front end of a NOR-style flash array model. It watches write cycles on the host bus. Each cycle is an address and a byte, qualified by an active-low write strobe. The block recognises the multi-cycle unlock sequences that select the device's operating modes. When a sequence completes, it issues a one-clock start pulse for byte program, chip erase or sector erase. With the pulse it presents the latched address and data to the embedded-operation engine.

The block also keeps an identifier mode flag. The read path uses this flag to choose between array data and the identifier byte. The identifier byte is looked up from a read offset. The write strobe is asynchronous to the clock. It is synchronised, filtered for glitches and turned into single write events. The address of a write is taken when the strobe falls and the data when the strobe rises.

While the engine reports busy, or while the supply is flagged low, command writes have no effect.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst` is high and after it is released, the decoder is in read mode: `id_mode` is 0 and no start pulse is issued.
- R2: The unlock prefix is byte 0xAA at address 0x555, then byte 0x55 at address 0x2AA, comparing the low 11 address bits. Writing 0x90 at 0x555 as the third cycle sets `id_mode` to 1.
- R3: `id_data` is 0x01 for `id_ofs` 0x00, 0xA4 for `id_ofs` 0x01 and 0x00 for every other offset. It appears one clock edge after `id_ofs` is applied.
- R4: A cycle with the wrong address or data, or a cycle out of order, returns the decoder to read mode. Such a cycle clears `id_mode` and issues no start pulse.
- R5: Prefix, then 0xA0 at 0x555, then any fourth cycle raises `prog_go` for exactly one clock. `op_addr` and `op_data` then carry the address and data of that fourth cycle.
- R6: Prefix, then 0x80 at 0x555, then 0xAA at 0x555, then 0x55 at 0x2AA, then 0x10 at 0x555 raises `chip_go` for one clock, with `op_data` = 0x10.
- R7: The same five cycles followed by 0x30 at any address raise `sect_go` for one clock, with `op_addr` equal to that address.
- R8: Byte 0xF0 written in any cycle except the program data cycle returns the decoder to read mode and clears `id_mode`.
- R9: `id_mode` stays 1 through the cycles of a later sequence until that sequence completes, fails or is reset.
- R10: While `busy` is high, writes are ignored: state, `id_mode` and the start pulses are unchanged.
- R11: A low pulse on `we_n` that lasts fewer than MIN_LOW clock cycles is not taken as a write.
- R12: While `low_vcc` is high, the decoder is held in read mode with `id_mode` 0, and writes are ignored.
- R13: The address is taken when the synchronised strobe falls and the data when it rises. Start pulses and `id_mode` change on the fourth clock edge after `we_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we_n | input | 1 | Asynchronous active-low write strobe |
| addr_in | input | AW | Bus address, sampled when the strobe falls |
| data_in | input | 8 | Bus data, sampled when the strobe rises |
| busy | input | 1 | Embedded operation running; writes ignored |
| low_vcc | input | 1 | Supply below lockout level; forces read mode |
| id_ofs | input | 8 | Offset for identifier reads |
| prog_go | output | 1 | One-clock byte program start |
| chip_go | output | 1 | One-clock chip erase start |
| sect_go | output | 1 | One-clock sector erase start |
| op_addr | output | AW | Address latched for the started operation |
| op_data | output | 8 | Data or command latched for the started operation |
| id_mode | output | 1 | Read path selects identifier data |
| id_data | output | 8 | Identifier byte for `id_ofs` |

## Verification
Every write passes through three synchroniser stages and one event register before the sequencer acts on it. A start pulse or an `id_mode` change is therefore due on the fourth rising edge after `we_n` goes high. The pulse is gone one edge later. The bench raises the strobe on a falling clock edge, counts exactly four rising edges and samples on the next falling edge. Identifier bytes are due one edge after `id_ofs` changes and are sampled on the falling edge that follows. Glitch, busy and low-supply cases are judged at that same sampling point by the absence of the change that a valid write would have made.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int BW = 8;
  localparam int UW = 11;

  localparam logic [UW-1:0] ADR_A = 11'h555;
  localparam logic [UW-1:0] ADR_B = 11'h2AA;

  localparam logic [BW-1:0] C_UNL1  = 8'hAA;
  localparam logic [BW-1:0] C_UNL2  = 8'h55;
  localparam logic [BW-1:0] C_PROG  = 8'hA0;
  localparam logic [BW-1:0] C_ERS   = 8'h80;
  localparam logic [BW-1:0] C_IDENT = 8'h90;
  localparam logic [BW-1:0] C_RESET = 8'hF0;
  localparam logic [BW-1:0] C_CHIP  = 8'h10;
  localparam logic [BW-1:0] C_SECT  = 8'h30;

  localparam logic [BW-1:0] ID_B0 = 8'h01;
  localparam logic [BW-1:0] ID_B1 = 8'hA4;

  typedef enum logic [2:0] {
    S_READ, S_U1, S_U2, S_PDATA, S_E1, S_E2, S_E3
  } seq_t;
endpackage

// File: rtl/fcd_strobe.sv
module fcd_strobe
  import fcd_pkg::*;
#(
  parameter int AW      = 19,
  parameter int MIN_LOW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_n,
  input  logic [AW-1:0] addr_in,
  input  logic [BW-1:0] data_in,
  output logic          wr_vld,
  output logic [AW-1:0] wr_addr,
  output logic [BW-1:0] wr_data
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_LOW);

  logic [2:0]    sync;
  logic [CW-1:0] low_cnt;
  logic [AW-1:0] addr_q;
  logic          fall, rise;

  // sync[1] is the synchronised strobe, sync[2] its previous value
  assign fall = sync[2] & ~sync[1];
  assign rise = ~sync[2] & sync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync    <= 3'b111;
      low_cnt <= '0;
      addr_q  <= '0;
      wr_vld  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      sync   <= {sync[1:0], we_n};
      wr_vld <= 1'b0;
      if (fall) begin
        addr_q  <= addr_in;
        low_cnt <= CW'(1);
      end else if (!sync[1] && low_cnt != CMAX) begin
        low_cnt <= low_cnt + CW'(1);
      end
      // accept only pulses that stayed low long enough
      if (rise && low_cnt == CMAX) begin
        wr_vld  <= 1'b1;
        wr_addr <= addr_q;
        wr_data <= data_in;
      end
    end
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_vld,
  input  logic [AW-1:0] wr_addr,
  input  logic [BW-1:0] wr_data,
  input  logic          busy,
  input  logic          low_vcc,
  output logic          prog_go,
  output logic          chip_go,
  output logic          sect_go,
  output logic [AW-1:0] op_addr,
  output logic [BW-1:0] op_data,
  output logic          id_mode
);
  seq_t st;
  logic at_a, at_b;

  assign at_a = (wr_addr[UW-1:0] == ADR_A);
  assign at_b = (wr_addr[UW-1:0] == ADR_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_READ;
      prog_go <= 1'b0;
      chip_go <= 1'b0;
      sect_go <= 1'b0;
      op_addr <= '0;
      op_data <= '0;
      id_mode <= 1'b0;
    end else begin
      prog_go <= 1'b0;
      chip_go <= 1'b0;
      sect_go <= 1'b0;
      if (low_vcc) begin
        st      <= S_READ;
        id_mode <= 1'b0;
      end else if (wr_vld && !busy) begin
        if (st == S_PDATA) begin
          prog_go <= 1'b1;
          op_addr <= wr_addr;
          op_data <= wr_data;
          st      <= S_READ;
          id_mode <= 1'b0;
        end else if (wr_data == C_RESET) begin
          st      <= S_READ;
          id_mode <= 1'b0;
        end else begin
          case (st)
            S_READ: begin
              if (at_a && wr_data == C_UNL1) st <= S_U1;
              else id_mode <= 1'b0;
            end
            S_U1: begin
              if (at_b && wr_data == C_UNL2) st <= S_U2;
              else begin st <= S_READ; id_mode <= 1'b0; end
            end
            S_U2: begin
              if (at_a && wr_data == C_PROG) st <= S_PDATA;
              else if (at_a && wr_data == C_ERS) st <= S_E1;
              else if (at_a && wr_data == C_IDENT) begin
                st <= S_READ; id_mode <= 1'b1;
              end else begin st <= S_READ; id_mode <= 1'b0; end
            end
            S_E1: begin
              if (at_a && wr_data == C_UNL1) st <= S_E2;
              else begin st <= S_READ; id_mode <= 1'b0; end
            end
            S_E2: begin
              if (at_b && wr_data == C_UNL2) st <= S_E3;
              else begin st <= S_READ; id_mode <= 1'b0; end
            end
            S_E3: begin
              if (at_a && wr_data == C_CHIP) begin
                chip_go <= 1'b1;
                op_addr <= wr_addr;
                op_data <= wr_data;
              end else if (wr_data == C_SECT) begin
                sect_go <= 1'b1;
                op_addr <= wr_addr;
                op_data <= wr_data;
              end
              st      <= S_READ;
              id_mode <= 1'b0;
            end
            default: begin st <= S_READ; id_mode <= 1'b0; end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/fcd_idrom.sv
module fcd_idrom
  import fcd_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    id_ofs,
  output logic [BW-1:0] id_data
);
  always_ff @(posedge clk) begin
    if (rst) id_data <= '0;
    else begin
      case (id_ofs)
        8'h00:   id_data <= ID_B0;
        8'h01:   id_data <= ID_B1;
        default: id_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int AW      = 19,
  parameter int MIN_LOW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_n,
  input  logic [AW-1:0] addr_in,
  input  logic [7:0]    data_in,
  input  logic          busy,
  input  logic          low_vcc,
  input  logic [7:0]    id_ofs,
  output logic          prog_go,
  output logic          chip_go,
  output logic          sect_go,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic          id_mode,
  output logic [7:0]    id_data
);
  logic          wr_vld;
  logic [AW-1:0] wr_addr;
  logic [BW-1:0] wr_data;

  fcd_strobe #(.AW(AW), .MIN_LOW(MIN_LOW)) u_strobe (
    .clk(clk), .rst(rst), .we_n(we_n), .addr_in(addr_in), .data_in(data_in),
    .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  fcd_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .low_vcc(low_vcc), .prog_go(prog_go), .chip_go(chip_go),
    .sect_go(sect_go), .op_addr(op_addr), .op_data(op_data), .id_mode(id_mode)
  );

  fcd_idrom u_idrom (
    .clk(clk), .rst(rst), .id_ofs(id_ofs), .id_data(id_data)
  );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          low_vcc,
  input logic [7:0]    id_ofs,
  input logic          prog_go,
  input logic          chip_go,
  input logic          sect_go,
  input logic [AW-1:0] op_addr,
  input logic          id_mode,
  input logic [7:0]    id_data
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> !id_mode && !prog_go && !chip_go && !sect_go);

  // R5
  start_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_go, chip_go, sect_go}));

  // R5
  prog_single_chk: assert property (@(posedge clk) disable iff (rst)
    prog_go |=> !prog_go);

  // R6
  chip_single_chk: assert property (@(posedge clk) disable iff (rst)
    chip_go |=> !chip_go);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !low_vcc |=> $stable(id_mode) && !prog_go && !chip_go && !sect_go);

  // R12
  low_supply_chk: assert property (@(posedge clk) disable iff (rst)
    low_vcc |=> !id_mode && !prog_go && !chip_go && !sect_go);

  // R3
  id_byte0_chk: assert property (@(posedge clk) disable iff (rst)
    id_ofs == 8'h00 |=> id_data == 8'h01);

  // R3
  id_byte1_chk: assert property (@(posedge clk) disable iff (rst)
    id_ofs == 8'h01 |=> id_data == 8'hA4);

  // R7
  sect_addr_chk: assert property (@(posedge clk) disable iff (rst)
    sect_go |=> $stable(op_addr));
endmodule

bind flash_cmd_decoder fcd_checker #(.AW(AW)) i_chk (
  .clk(clk), .rst(rst), .busy(busy), .low_vcc(low_vcc), .id_ofs(id_ofs),
  .prog_go(prog_go), .chip_go(chip_go), .sect_go(sect_go), .op_addr(op_addr),
  .id_mode(id_mode), .id_data(id_data)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
  localparam int AW = 19;
  localparam int NV = 31;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [7:0]    data_in = '0;
  logic          busy = 1'b0;
  logic          low_vcc = 1'b0;
  logic [7:0]    id_ofs = 8'h55;
  logic          prog_go, chip_go, sect_go, id_mode;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data, id_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_decoder #(.AW(AW), .MIN_LOW(3)) i_flash_cmd_decoder (
    .clk(clk), .rst(rst), .we_n(we_n), .addr_in(addr_in), .data_in(data_in),
    .busy(busy), .low_vcc(low_vcc), .id_ofs(id_ofs), .prog_go(prog_go),
    .chip_go(chip_go), .sect_go(sect_go), .op_addr(op_addr), .op_data(op_data),
    .id_mode(id_mode), .id_data(id_data)
  );

  // {addr, data, expected {prog_go, chip_go, sect_go, id_mode}}
  localparam logic [30:0] VEC [NV] = '{
    {19'h00555, 8'hAA, 4'b0000},
    {19'h002AA, 8'h55, 4'b0000},
    {19'h00555, 8'h90, 4'b0001},  // R2 identifier entry
    {19'h00123, 8'hF0, 4'b0000},  // R8 reset byte
    {19'h00555, 8'hAA, 4'b0000},
    {19'h002AA, 8'h55, 4'b0000},
    {19'h00555, 8'hA0, 4'b0000},
    {19'h00ABC, 8'h3C, 4'b1000},  // R5 program
    {19'h00555, 8'hAA, 4'b0000},
    {19'h002AA, 8'h55, 4'b0000},
    {19'h00555, 8'h80, 4'b0000},
    {19'h00555, 8'hAA, 4'b0000},
    {19'h002AA, 8'h55, 4'b0000},
    {19'h00555, 8'h10, 4'b0100},  // R6 chip erase
    {19'h00555, 8'hAA, 4'b0000},
    {19'h002AA, 8'h55, 4'b0000},
    {19'h00555, 8'h80, 4'b0000},
    {19'h00555, 8'hAA, 4'b0000},
    {19'h002AA, 8'h55, 4'b0000},
    {19'h41234, 8'h30, 4'b0010},  // R7 sector erase
    {19'h00555, 8'hAA, 4'b0000},
    {19'h002AA, 8'h66, 4'b0000},  // R4 bad data
    {19'h00555, 8'hA0, 4'b0000},  // R4 out of order
    {19'h00100, 8'h00, 4'b0000},  // R4 no program
    {19'h00555, 8'hAA, 4'b0000},
    {19'h002AA, 8'h55, 4'b0000},
    {19'h00555, 8'h90, 4'b0001},
    {19'h00555, 8'hAA, 4'b0001},  // R9 mode persists
    {19'h002AA, 8'h55, 4'b0001},
    {19'h00555, 8'hA0, 4'b0001},
    {19'h00200, 8'h5A, 4'b1000}   // R9 cleared on completion
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input int lw);
    @(negedge clk);
    addr_in = a; data_in = d; we_n = 1'b0;
    repeat (lw) @(negedge clk);
    we_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  // address valid only around the fall, data only around the rise
  task automatic wr_skew(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_in = a; data_in = 8'h00; we_n = 1'b0;
    repeat (3) @(negedge clk);
    addr_in = '1;
    repeat (2) @(negedge clk);
    we_n = 1'b1; data_in = d;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic enter_id();
    wr(19'h00555, 8'hAA, 5);
    wr(19'h002AA, 8'h55, 5);
    wr(19'h00555, 8'h90, 5);
  endtask

  function automatic logic [3:0] outs();
    return {prog_go, chip_go, sect_go, id_mode};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {28'd0, outs()}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 outputs after reset", {28'd0, outs()}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      string tag;
      v = VEC[i];
      wr(v[30:12], v[11:4], 5);
      if (v[3]) tag = "R5 program";
      else if (v[2]) tag = "R6 chip erase";
      else if (v[1]) tag = "R7 sector erase";
      else if (v[0]) tag = "R2/R9 id mode";
      else tag = "R2/R4 step";
      chk(tag, {28'd0, outs()}, {28'd0, v[3:0]});
      if (v[3]) begin
        chk("R5 op_addr", {13'd0, op_addr}, {13'd0, v[30:12]});
        chk("R5 op_data", {24'd0, op_data}, {24'd0, v[11:4]});
      end
      if (v[2]) chk("R6 op_data", {24'd0, op_data}, 32'h10);
      if (v[1]) chk("R7 op_addr", {13'd0, op_addr}, {13'd0, v[30:12]});
      if (v[3] | v[2] | v[1]) begin
        @(negedge clk);
        chk("R5 start pulse one clock", {29'd0, prog_go, chip_go, sect_go}, 32'd0);
      end
    end

    // R3 identifier bytes, one edge after offset
    id_ofs = 8'h00; @(negedge clk);
    chk("R3 offset 0", {24'd0, id_data}, 32'h01);
    id_ofs = 8'h01; @(negedge clk);
    chk("R3 offset 1", {24'd0, id_data}, 32'hA4);
    id_ofs = 8'h77; @(negedge clk);
    chk("R3 other offset", {24'd0, id_data}, 32'h00);

    // R11 short strobes rejected
    wr(19'h00555, 8'hAA, 5);
    wr(19'h002AA, 8'h55, 5);
    wr(19'h00555, 8'h90, 1);
    chk("R11 one-cycle glitch", {31'd0, id_mode}, 32'd0);
    wr(19'h00555, 8'h90, 2);
    chk("R11 two-cycle glitch", {31'd0, id_mode}, 32'd0);
    wr(19'h00555, 8'h90, 3);
    chk("R11 minimum width accepted", {31'd0, id_mode}, 32'd1);
    wr(19'h00000, 8'hF0, 5);
    chk("R8 reset byte", {31'd0, id_mode}, 32'd0);

    // R13 address at fall, data at rise
    wr(19'h00555, 8'hAA, 5);
    wr(19'h002AA, 8'h55, 5);
    wr_skew(19'h00555, 8'h90);
    chk("R13 capture edges", {31'd0, id_mode}, 32'd1);

    // R10 busy ignores writes
    busy = 1'b1;
    wr(19'h00000, 8'hF0, 5);
    chk("R10 reset ignored while busy", {31'd0, id_mode}, 32'd1);
    wr(19'h00555, 8'hAA, 5);
    wr(19'h002AA, 8'h55, 5);
    wr(19'h00555, 8'hA0, 5);
    wr(19'h00300, 8'h11, 5);
    chk("R10 program ignored while busy", {28'd0, outs()}, 32'd1);
    busy = 1'b0;
    wr(19'h00000, 8'hF0, 5);
    chk("R10 writes resume", {31'd0, id_mode}, 32'd0);

    // R12 low supply
    enter_id();
    low_vcc = 1'b1;
    @(negedge clk);
    chk("R12 forced read mode", {31'd0, id_mode}, 32'd0);
    wr(19'h00555, 8'hAA, 5);
    low_vcc = 1'b0;
    wr(19'h002AA, 8'h55, 5);
    wr(19'h00555, 8'h90, 5);
    chk("R12 write blocked during low supply", {31'd0, id_mode}, 32'd0);

    // R1 reset mid-operation
    enter_id();
    chk("R1 id before reset", {31'd0, id_mode}, 32'd1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset clears mode", {28'd0, outs()}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule